// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block is a DMA engine that walks a chain of transmit descriptors stored in memory and streams the referenced frame bytes onto a byte-wide valid/ready output. Every descriptor occupies two 32-bit words. The first word holds control bits, with a 4-bit type code at the top and a 12-bit byte count at the bottom. The second word holds a byte pointer. The type code decides what the engine does with the descriptor. It may send a data buffer, jump to a new descriptor address, or stop.

Software first prepares a table of base descriptors in memory and puts the table's byte address on `base_addr`. It then pulses `start_req`. The first start after reset makes the engine fetch the transmit queue entry of that table, which is normally a link into a ring of descriptors. For each data descriptor the engine sends its buffer, marks the descriptor complete by rewriting its type code, and moves on to the next descriptor. When it meets a descriptor it cannot process, it drops its run flag and parks at that address. Software can then fill the descriptor and pulse `start_req` again to resume from it.

Memory is reached through a word-addressed port with a single outstanding request. A request is accepted in a cycle where `mem_req` and `mem_ready` are both high. Read data returns on a later cycle, flagged by `mem_rvalid`.

Top module: `txd_chain_engine`

## Requirements
- R1: After reset `run_o`, `mem_req` and `tx_valid` are all low.
- R2: A `start_req` pulse sets `run_o` from the next cycle. The first start after reset makes the engine read its first control word at byte address `base_addr + 8*QUEUE_IDX`, where QUEUE_IDX defaults to 0.
- R3: A control word with type code 0x9 in bits 31:28 is a link. The engine reads the pointer word at descriptor address + 4, sends no bytes, and fetches its next control word at the byte address held in that pointer.
- R4: A control word with type code 0x7 is a data descriptor. Its byte count is in bits 11:0 and its buffer starts at the byte address held in the pointer word. The engine sends exactly that many bytes, in address order, and the buffer address may be unaligned. The byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of memory word A/4. `tx_last` is high on the final byte only.
- R5: Once a data descriptor's bytes have all been accepted, the engine writes its control word back to the same address. Bits 31:28 become 0x3 and bits 27:0 are unchanged.
- R6: After the write-back is accepted, the next control word is read at descriptor address + 8. Several ready data descriptors are therefore sent one after another within a single start.
- R7: A data descriptor with a byte count of 0 sends no bytes and is still written back as in R5.
- R8: Any type code other than 0x7 or 0x9 (for example 0xA, 0xC, 0x3 or 0x5) clears `run_o`. Such a descriptor sends no bytes and causes no memory write. The engine keeps its address, so the next `start_req` reads that same control word again.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle pulse that sets the run flag |
| base_addr | input | AW | Byte address of the base descriptor table |
| run_o | output | 1 | Run flag; cleared by the engine when it stops |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (write-back) |
| mem_addr | output | AW-2 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
Suppose the byte-lane pointer or the remaining count goes wrong. The stream then shows a wrong byte, a missing or extra byte, or a misplaced `tx_last` within the frame that is being sent. Suppose instead the descriptor address goes wrong. That shows up at the next control fetch as an out-of-place read address, and then as a write-back landing on the wrong word or a frame that is never sent. The bench therefore compares every streamed byte, every write-back word and the last control address fetched before each stop against values computed from the descriptor layout it wrote itself.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam logic [3:0] CODE_DATA = 4'h7;
   localparam logic [3:0] CODE_LINK = 4'h9;
   localparam logic [3:0] CODE_DONE = 4'h3;

   typedef enum logic [1:0] {
      K_DATA,
      K_LINK,
      K_STOP
   } kind_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CTRL_REQ,
      S_CTRL_WAIT,
      S_PTR_REQ,
      S_PTR_WAIT,
      S_DATA_REQ,
      S_DATA_WAIT,
      S_EMIT,
      S_WB_REQ
   } state_e;
endpackage

// File: rtl/txd_desc_decode.sv
module txd_desc_decode
   import txd_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic [3:0]       code_i,
   input  logic [LEN_W-1:0] len_field_i,
   output kind_e            kind_o,
   output logic [LEN_W-1:0] len_o,
   output logic             len_zero_o
);
   always_comb begin
      if (code_i == CODE_DATA)      kind_o = K_DATA;
      else if (code_i == CODE_LINK) kind_o = K_LINK;
      else                          kind_o = K_STOP;
   end

   assign len_o      = len_field_i;
   assign len_zero_o = (len_field_i == '0);
endmodule

// File: rtl/txd_byte_pick.sv
module txd_byte_pick #(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  lane_i,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_ENDIAN) begin : g_big
         assign byte_o = word_i[{~lane_i, 3'b000} +: 8];
      end else begin : g_little
         assign byte_o = word_i[{lane_i, 3'b000} +: 8];
      end
   endgenerate
endmodule

// File: rtl/txd_run_flag.sv
module txd_run_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic run_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     run_o <= 1'b0;
      else if (set_i) run_o <= 1'b1;
      else if (clr_i) run_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> run_o); // R2
endmodule

// File: rtl/txd_chain_engine.sv
module txd_chain_engine
   import txd_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LEN_W        = 12,
   parameter int BASE_ENTRIES = 16,
   parameter int QUEUE_IDX    = 0,
   parameter bit BIG_ENDIAN   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic [AW-1:0] base_addr,
   output logic          run_o,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-3:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   output logic [7:0]    tx_data,
   output logic          tx_valid,
   output logic          tx_last,
   input  logic          tx_ready
);
   localparam int            DESC_BYTES = 8;
   localparam logic [AW-1:0] DESC_STEP  = AW'(DESC_BYTES);
   localparam logic [AW-1:0] PTR_OFS    = AW'(4);
   localparam logic [AW-1:0] QUEUE_OFS  = AW'(QUEUE_IDX * DESC_BYTES);
   localparam logic [AW-3:0] WORD_STEP  = (AW-2)'(DESC_BYTES / 4);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("AW must lie between 8 and 32");
      end
      if (LEN_W < 1 || LEN_W > 28) begin : g_bad_len
         $error("LEN_W must lie between 1 and 28");
      end
      if (QUEUE_IDX < 0 || QUEUE_IDX >= BASE_ENTRIES) begin : g_bad_idx
         $error("QUEUE_IDX must index the base table");
      end
   endgenerate

   state_e           st_q;
   logic [AW-1:0]    cur_q;
   logic [AW-1:0]    buf_q;
   logic [LEN_W-1:0] rem_q;
   logic [31:0]      ctrl_q;
   logic [31:0]      word_q;
   logic             loaded_q;
   logic [AW-1:0]    addr_mux;
   logic [1:0]       unused_addr_lo;
   logic             stop_evt;

   kind_e            live_kind;
   logic [LEN_W-1:0] unused_live_len;
   logic             unused_live_zero;
   kind_e            held_kind;
   logic [LEN_W-1:0] held_len;
   logic             held_zero;

   txd_desc_decode #(.LEN_W(LEN_W)) u_dec_live (
      .code_i      (mem_rdata[31:28]),
      .len_field_i (mem_rdata[LEN_W-1:0]),
      .kind_o      (live_kind),
      .len_o       (unused_live_len),
      .len_zero_o  (unused_live_zero)
   );

   txd_desc_decode #(.LEN_W(LEN_W)) u_dec_held (
      .code_i      (ctrl_q[31:28]),
      .len_field_i (ctrl_q[LEN_W-1:0]),
      .kind_o      (held_kind),
      .len_o       (held_len),
      .len_zero_o  (held_zero)
   );

   assign stop_evt = (st_q == S_CTRL_WAIT) && mem_rvalid && (live_kind == K_STOP);

   txd_run_flag u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (start_req),
      .clr_i (stop_evt),
      .run_o (run_o)
   );

   txd_byte_pick #(.BIG_ENDIAN(BIG_ENDIAN)) u_pick (
      .word_i (word_q),
      .lane_i (buf_q[1:0]),
      .byte_o (tx_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         cur_q    <= '0;
         buf_q    <= '0;
         rem_q    <= '0;
         ctrl_q   <= '0;
         word_q   <= '0;
         loaded_q <= 1'b0;
      end else begin
         if (start_req && !loaded_q) begin
            cur_q    <= base_addr + QUEUE_OFS;
            loaded_q <= 1'b1;
         end
         case (st_q)
            S_IDLE: if (run_o) st_q <= S_CTRL_REQ;
            S_CTRL_REQ: if (mem_ready) st_q <= S_CTRL_WAIT;
            S_CTRL_WAIT: if (mem_rvalid) begin
               ctrl_q <= mem_rdata;
               st_q   <= (live_kind == K_STOP) ? S_IDLE : S_PTR_REQ;
            end
            S_PTR_REQ: if (mem_ready) st_q <= S_PTR_WAIT;
            S_PTR_WAIT: if (mem_rvalid) begin
               if (held_kind == K_LINK) begin
                  cur_q <= mem_rdata[AW-1:0];
                  st_q  <= S_CTRL_REQ;
               end else begin
                  buf_q <= mem_rdata[AW-1:0];
                  rem_q <= held_len;
                  st_q  <= held_zero ? S_WB_REQ : S_DATA_REQ;
               end
            end
            S_DATA_REQ: if (mem_ready) st_q <= S_DATA_WAIT;
            S_DATA_WAIT: if (mem_rvalid) begin
               word_q <= mem_rdata;
               st_q   <= S_EMIT;
            end
            S_EMIT: if (tx_ready) begin
               buf_q <= buf_q + AW'(1);
               rem_q <= rem_q - LEN_W'(1);
               if (rem_q == LEN_W'(1))        st_q <= S_WB_REQ;
               else if (buf_q[1:0] == 2'b11)  st_q <= S_DATA_REQ;
            end
            S_WB_REQ: if (mem_ready) begin
               cur_q <= cur_q + DESC_STEP;
               st_q  <= S_CTRL_REQ;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         S_PTR_REQ:  addr_mux = cur_q + PTR_OFS;
         S_DATA_REQ: addr_mux = buf_q;
         default:    addr_mux = cur_q;
      endcase
   end

   assign unused_addr_lo = addr_mux[1:0];
   assign mem_addr  = addr_mux[AW-1:2];
   assign mem_req   = (st_q == S_CTRL_REQ) || (st_q == S_PTR_REQ) ||
                      (st_q == S_DATA_REQ) || (st_q == S_WB_REQ);
   assign mem_we    = (st_q == S_WB_REQ);
   assign mem_wdata = {CODE_DONE, ctrl_q[27:0]};
   assign tx_valid  = (st_q == S_EMIT);
   assign tx_last   = (rem_q == LEN_W'(1));

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
   AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R9
   AST_LAST_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> (mem_req && mem_we && !tx_valid)); // R5
   AST_WB_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=>
         (mem_req && !mem_we && mem_addr == $past(mem_addr) + WORD_STEP)); // R6
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |-> (!mem_req && !tx_valid)); // R8
endmodule

// File: tb/test_txd_chain_engine.sv
module test_txd_chain_engine;
   localparam int AW = 32;
   localparam int BASE_B = 32'h100;
   localparam int RING_B = 32'h200;
   localparam int BUF_B  = 32'h400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_req = 1'b0;
   logic [AW-1:0] base_addr = AW'(BASE_B);
   logic          run_o;
   logic          mem_req, mem_we;
   logic [AW-3:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic          mem_ready = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [31:0]   mem_rdata = '0;
   logic [7:0]    tx_data;
   logic          tx_valid, tx_last;
   logic          tx_ready = 1'b0;

   always #5 clk = ~clk;

   txd_chain_engine #(.AW(AW)) i_txd_chain_engine (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .base_addr(base_addr),
      .run_o(run_o), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_ready(tx_ready)
   );

   // memory model, host write port, monitors
   logic [31:0] mem [0:1023];
   logic        h_we = 1'b0;
   logic [9:0]  h_a = '0;
   logic [31:0] h_d = '0;
   logic        acc_q = 1'b0, acc_we_q = 1'b0;
   logic [9:0]  acc_a_q = '0;
   logic [31:0] acc_d_q = '0;
   logic [7:0]  rx_b [0:4095];
   logic        rx_l [0:4095];
   int          rx_n = 0;
   logic [29:0] rd_log [0:255];
   int          rd_n = 0;
   int          checks = 0, fails = 0;

   always @(negedge clk) begin
      acc_q    = rst_n && mem_req && mem_ready;
      acc_we_q = mem_we;
      acc_a_q  = mem_addr[9:0];
      acc_d_q  = mem_wdata;
      if (acc_q && !mem_we) begin
         rd_log[rd_n % 256] = mem_addr;
         rd_n = rd_n + 1;
      end
      if (rst_n && tx_valid && tx_ready) begin
         rx_b[rx_n % 4096] = tx_data;
         rx_l[rx_n % 4096] = tx_last;
         rx_n = rx_n + 1;
      end
   end

   always @(posedge clk) begin
      mem_ready  <= ($urandom % 4) != 0;
      tx_ready   <= ($urandom % 3) != 0;
      mem_rvalid <= 1'b0;
      if (h_we) mem[h_a] <= h_d;
      if (acc_q) begin
         if (acc_we_q) mem[acc_a_q] <= acc_d_q;
         else begin
            mem_rdata  <= mem[acc_a_q];
            mem_rvalid <= 1'b1;
         end
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37) ^ (a >> 5) ^ 32'h5A);
   endfunction

   function automatic int ring_w(input int idx);
      return (RING_B + 8 * idx) / 4;
   endfunction

   function automatic int nxt(input int idx);
      return (idx + 1) % 7;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic host_wr(input int widx, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_a = widx[9:0]; h_d = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (2) @(negedge clk);
      while (run_o && n < 5000) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
      chk(!run_o, "R8", "engine stopped", 32'(run_o), 32'd0);
   endtask

   task automatic check_bytes(input int first, input int len, input int baddr, input int fr_end);
      for (int i = 0; i < len; i++) begin
         chk(rx_b[(first + i) % 4096] == pat(baddr + i), "R4", "byte value",
             32'(rx_b[(first + i) % 4096]), 32'(pat(baddr + i)));
         chk(rx_l[(first + i) % 4096] == (i == len - 1 && fr_end == 1), "R4", "last flag",
             32'(rx_l[(first + i) % 4096]), 32'(i == len - 1 && fr_end == 1));
      end
   endtask

   task automatic send_frame(input int idx, input int len, input int off);
      logic [31:0] ctrl;
      int first, baddr;
      baddr = BUF_B + off;
      ctrl  = {4'h7, 16'($urandom), 12'(len)};
      host_wr(ring_w(idx), ctrl);
      host_wr(ring_w(idx) + 1, 32'(baddr));
      first = rx_n;
      pulse_start();
      wait_idle();
      chk(rx_n - first == len, (len == 0) ? "R7" : "R4", "byte count", 32'(rx_n - first), 32'(len));
      check_bytes(first, len, baddr, 1);
      chk(mem[ring_w(idx)] == {4'h3, ctrl[27:0]}, (len == 0) ? "R7" : "R5", "write-back",
          mem[ring_w(idx)], {4'h3, ctrl[27:0]});
      chk(rd_log[(rd_n - 1) % 256] == 30'(ring_w(nxt(idx))), "R6", "next control fetch",
          32'(rd_log[(rd_n - 1) % 256]), 32'(ring_w(nxt(idx))));
   endtask

   task automatic send_pair(input int p, input int la, input int oa, input int lb, input int ob);
      logic [31:0] ca, cb;
      int first, q;
      q  = nxt(p);
      ca = {4'h7, 16'($urandom), 12'(la)};
      cb = {4'h7, 16'($urandom), 12'(lb)};
      host_wr(ring_w(p), ca);  host_wr(ring_w(p) + 1, 32'(BUF_B + oa));
      host_wr(ring_w(q), cb);  host_wr(ring_w(q) + 1, 32'(BUF_B + ob));
      first = rx_n;
      pulse_start();
      wait_idle();
      chk(rx_n - first == la + lb, "R6", "two frames in one start", 32'(rx_n - first), 32'(la + lb));
      check_bytes(first, la, BUF_B + oa, 1);
      check_bytes(first + la, lb, BUF_B + ob, 1);
      chk(mem[ring_w(q)] == {4'h3, cb[27:0]}, "R5", "second write-back", mem[ring_w(q)], {4'h3, cb[27:0]});
   endtask

   task automatic stop_code(input int idx, input logic [3:0] code);
      logic [31:0] ctrl;
      int first;
      ctrl = {code, 28'($urandom)};
      host_wr(ring_w(idx), ctrl);
      first = rx_n;
      pulse_start();
      wait_idle();
      chk(rx_n == first, "R8", "no bytes on stop code", 32'(rx_n - first), 32'd0);
      chk(mem[ring_w(idx)] == ctrl, "R8", "stop descriptor not written", mem[ring_w(idx)], ctrl);
      chk(rd_log[(rd_n - 1) % 256] == 30'(ring_w(idx)), "R8", "address held",
          32'(rd_log[(rd_n - 1) % 256]), 32'(ring_w(idx)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
   end

   initial begin
      int pos;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!run_o && !mem_req && !tx_valid, "R1", "reset state",
          {29'd0, run_o, mem_req, tx_valid}, 32'd0);

      for (int w = BUF_B / 4; w < 32'hC00 / 4; w++)
         host_wr(w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
      for (int e = 0; e < 16; e++) begin
         host_wr(BASE_B / 4 + 2 * e, (e == 0) ? 32'h9000_0000 : 32'hA000_0000);
         host_wr(BASE_B / 4 + 2 * e + 1, (e == 0) ? 32'(RING_B) : 32'd0);
      end
      for (int i = 0; i < 8; i++) begin
         host_wr(ring_w(i), (i == 7) ? 32'h9000_0000 : 32'h3000_0000);
         host_wr(ring_w(i) + 1, (i == 7) ? 32'(RING_B) : 32'd0);
      end
      chk(!run_o, "R1", "idle before first start", 32'(run_o), 32'd0);

      // first start: base entry, then link into ring
      send_frame(0, 5, 0);
      chk(rd_log[0] == 30'(BASE_B / 4), "R2", "first fetch at base entry", 32'(rd_log[0]), BASE_B / 4);
      chk(rd_log[1] == 30'(BASE_B / 4 + 1), "R3", "link pointer read", 32'(rd_log[1]), BASE_B / 4 + 1);
      chk(rd_log[2] == 30'(RING_B / 4), "R3", "link followed", 32'(rd_log[2]), RING_B / 4);
      send_frame(1, 0, 8);      // R7 zero length
      send_frame(2, 1, 3);      // single unaligned byte
      send_frame(3, 9, 1);      // crosses word boundaries
      pos = 4;
      for (int k = 0; k < 14; k++) begin
         send_frame(pos, 1 + int'($urandom % 40), int'($urandom % 1800));
         pos = nxt(pos);       // wraps through the ring link (R3)
      end
      send_pair(pos, 1 + int'($urandom % 30), int'($urandom % 1800), 7, 2);
      pos = nxt(nxt(pos));
      stop_code(pos, 4'hC);
      stop_code(pos, 4'hA);
      stop_code(pos, 4'h5);
      send_frame(pos, 12, 6);   // resumes at the held address (R8)
      pos = nxt(pos);
      send_frame(pos, 0, 0);
      pos = nxt(pos);
      send_frame(pos, 40, 1795);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule